// File: doc/BRIEF.md
# Write-Through Data Cache with Store Queue

This block is a direct-mapped data cache that sits between a processor load/store port and a single memory port. It holds 32 lines of 32 bytes. A 32-bit address is split into a byte offset in bits [4:0], a line index in bits [9:5] and a 22-bit tag in bits [31:10]. Each line keeps a valid flag and its tag. Loads that hit return data in the same cycle. Loads that miss fetch the whole line from memory, one 32-bit word per beat.

Every accepted store updates the cache if its line is present. It is also placed in a four-entry store queue, which carries the word address, byte enables and data. The memory side drains that queue one write at a time, so memory always ends up holding every store. A static parameter selects what a store miss does. It either leaves the cache untouched and goes only to memory, or it fetches the line first and then writes it.

The processor port has a single ready signal. Ready stays low while a line fetch is under way, while a miss waits for the queue to empty, and while the queue is full.

Top module: `wt_cache`

## Requirements
- R1: After reset no memory request is active and every line is invalid, so the first load to any address causes a line fetch.
- R2: The line index is address bits [9:5] and the tag is bits [31:10]. Two addresses with the same index and different tags evict each other. Addresses with different indexes can be held together.
- R3: A load that hits is accepted in the cycle it is presented. It returns the cached word in that cycle and causes no memory transfer.
- R4: A load miss issues exactly 8 memory reads, with all 4 byte enables set, at the line base address plus 0, 4, ... 28 in that order. It issues no memory write of its own. The processor is held until the last beat has arrived, and the line becomes valid only then.
- R5: A store that hits, presented while the queue is not full, is accepted in that cycle. It changes only the bytes whose enable is set: enable bit i covers data bits [8i+7:8i].
- R6: Every accepted store reaches memory as one write with the same word address, byte enables and data. These writes leave in the order the stores were accepted, and memory ends up equal to the processor's view.
- R7: At most 4 stores are pending. A store presented while 4 are pending waits until a memory write completes.
- R8: With write-around (WRITE_ALLOC = 0), a store miss is accepted without any line fetch and leaves the cache unchanged.
- R9: With write-allocate (WRITE_ALLOC = 1), a store miss first fetches the line with 8 reads and then performs the store into the cache as well as into the queue.
- R10: A line fetch starts only when the store queue is empty, so a fetch never returns data older than a pending store.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_req | input | 1 | Processor access request, held until accepted |
| cpu_we | input | 1 | 1 = store, 0 = load |
| cpu_addr | input | 32 | Byte address (word aligned) |
| cpu_be | input | 4 | Store byte enables |
| cpu_wdata | input | 32 | Store data |
| cpu_ready | output | 1 | Access accepted at this clock edge |
| cpu_rdata | output | 32 | Load data, valid while cpu_ready is high for a load |
| mem_req | output | 1 | Memory transfer request, held until acknowledged |
| mem_we | output | 1 | 1 = write from store queue, 0 = line-fill read |
| mem_addr | output | 32 | Memory byte address |
| mem_be | output | 4 | Memory byte enables |
| mem_wdata | output | 32 | Memory write data |
| mem_ack | input | 1 | Memory transfer done at this edge |
| mem_rdata | input | 32 | Read data, valid with mem_ack |

## Verification
A corrupted valid bit or tag appears at once as a wrong hit or miss. It shows up either as read data that differs from the processor's view in the very cycle ready rises, or as a fetch count different from 8 or 0. Errors in the queue pointers or count appear at the memory port within one drain latency. They show as a write whose address, enables or data do not match the oldest accepted store, or as a store admitted while 4 are pending. A fetch started too early shows on the first read beat, which the bench flags whenever its own count of pending stores is nonzero. A stale fetched word appears on the next load of that line.

// File: rtl/wtc_pkg.sv
package wtc_pkg;
    localparam int ADDR_W = 32;
    localparam int WORD_W = 32;
    localparam int BE_W   = WORD_W / 8;

    typedef struct packed {
        logic [ADDR_W-1:2] waddr;
        logic [BE_W-1:0]   be;
        logic [WORD_W-1:0] data;
    } wb_entry_t;

    typedef enum logic {ST_IDLE, ST_FILL} ctl_state_t;

    function automatic logic [WORD_W-1:0] merge_bytes(input logic [WORD_W-1:0] old_w,
                                                      input logic [WORD_W-1:0] new_w,
                                                      input logic [BE_W-1:0]   be);
        logic [WORD_W-1:0] r;
        r = old_w;
        for (int i = 0; i < BE_W; i++) begin
            if (be[i]) r[8*i +: 8] = new_w[8*i +: 8];
        end
        return r;
    endfunction
endpackage

// File: rtl/wtc_wbuf.sv
module wtc_wbuf
    import wtc_pkg::*;
#(
    parameter int DEPTH = 4,
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      push,
    input  wb_entry_t push_data,
    input  logic      pop,
    output wb_entry_t head,
    output logic      empty,
    output logic      full
);
    wb_entry_t        slots [DEPTH];
    logic [PTR_W-1:0] wr_ptr, rd_ptr;
    logic [CNT_W-1:0] count;

    function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    assign empty = (count == '0);
    assign full  = (count == CNT_W'(DEPTH));
    assign head  = slots[rd_ptr];

    always_ff @(posedge clk) begin
        if (push) slots[wr_ptr] <= push_data;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (push) wr_ptr <= bump(wr_ptr);
            if (pop)  rd_ptr <= bump(rd_ptr);
            case ({push, pop})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end

    // R7: the controller never pushes into a full queue
    p_no_overflow_r7: assert property (@(posedge clk) disable iff (rst) push |-> !full);
    // R6: a memory write is only retired when an entry exists
    p_no_underflow_r6: assert property (@(posedge clk) disable iff (rst) pop |-> !empty);
endmodule

// File: rtl/wtc_lines.sv
module wtc_lines
    import wtc_pkg::*;
#(
    parameter int LINES = 32,
    parameter int WORDS = 8,
    parameter int TAG_W = 22,
    localparam int IDX_W  = $clog2(LINES),
    localparam int WOFF_W = $clog2(WORDS)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [IDX_W-1:0]  rd_idx,
    input  logic [WOFF_W-1:0] rd_woff,
    input  logic [TAG_W-1:0]  rd_tag,
    output logic              hit,
    output logic [WORD_W-1:0] rd_word,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [WOFF_W-1:0] wr_woff,
    input  logic [BE_W-1:0]   wr_be,
    input  logic [WORD_W-1:0] wr_data,
    input  logic              clr_en,
    input  logic [IDX_W-1:0]  clr_idx,
    input  logic              set_en,
    input  logic [IDX_W-1:0]  set_idx,
    input  logic [TAG_W-1:0]  set_tag
);
    logic [WORD_W-1:0] words_q [LINES*WORDS];
    logic [TAG_W-1:0]  tag_q   [LINES];
    logic [LINES-1:0]  valid_q;

    assign hit     = valid_q[rd_idx] && (tag_q[rd_idx] == rd_tag);
    assign rd_word = words_q[{rd_idx, rd_woff}];

    always_ff @(posedge clk) begin
        if (wr_en)
            words_q[{wr_idx, wr_woff}] <= merge_bytes(words_q[{wr_idx, wr_woff}], wr_data, wr_be);
    end

    always_ff @(posedge clk) begin
        if (set_en) tag_q[set_idx] <= set_tag;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            valid_q <= '0;
        end else begin
            if (clr_en) valid_q[clr_idx] <= 1'b0;
            if (set_en) valid_q[set_idx] <= 1'b1;
        end
    end
endmodule

// File: rtl/wt_cache.sv
module wt_cache
    import wtc_pkg::*;
#(
    parameter int LINE_BYTES  = 32,
    parameter int NUM_LINES   = 32,
    parameter int WB_DEPTH    = 4,
    parameter bit WRITE_ALLOC = 1'b0
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        cpu_req,
    input  logic        cpu_we,
    input  logic [31:0] cpu_addr,
    input  logic [3:0]  cpu_be,
    input  logic [31:0] cpu_wdata,
    output logic        cpu_ready,
    output logic [31:0] cpu_rdata,
    output logic        mem_req,
    output logic        mem_we,
    output logic [31:0] mem_addr,
    output logic [3:0]  mem_be,
    output logic [31:0] mem_wdata,
    input  logic        mem_ack,
    input  logic [31:0] mem_rdata
);
    localparam int OFF_W  = $clog2(LINE_BYTES);
    localparam int IDX_W  = $clog2(NUM_LINES);
    localparam int TAG_W  = ADDR_W - OFF_W - IDX_W;
    localparam int WORDS  = LINE_BYTES / BE_W;
    localparam int WOFF_W = $clog2(WORDS);

    logic [TAG_W-1:0]  a_tag;
    logic [IDX_W-1:0]  a_idx;
    logic [WOFF_W-1:0] a_woff;
    assign a_tag  = cpu_addr[ADDR_W-1 -: TAG_W];
    assign a_idx  = cpu_addr[OFF_W +: IDX_W];
    assign a_woff = cpu_addr[2 +: WOFF_W];

    ctl_state_t        state;
    logic [WOFF_W-1:0] beat;
    logic [IDX_W-1:0]  fill_idx;
    logic [TAG_W-1:0]  fill_tag;

    logic        hit, in_fill, wants_fill, start_fill, last_beat;
    logic        wb_push, wb_pop, wb_empty, wb_full, ln_wr;
    wb_entry_t   wb_head, wb_in;
    logic [31:0] line_word;

    assign in_fill    = (state == ST_FILL);
    assign wants_fill = !cpu_we || WRITE_ALLOC;
    assign start_fill = !in_fill && cpu_req && !hit && wants_fill && wb_empty;
    assign last_beat  = in_fill && mem_ack && (beat == WOFF_W'(WORDS - 1));

    always_comb begin
        cpu_ready = 1'b0;
        if (!in_fill && cpu_req) begin
            if (cpu_we) cpu_ready = !wb_full && (hit || !WRITE_ALLOC);
            else        cpu_ready = hit;
        end
    end
    assign cpu_rdata = line_word;

    assign wb_push = cpu_req && cpu_we && cpu_ready;
    assign wb_in   = '{waddr: cpu_addr[ADDR_W-1:2], be: cpu_be, data: cpu_wdata};
    assign wb_pop  = !in_fill && !wb_empty && mem_ack;

    assign mem_req   = in_fill || !wb_empty;
    assign mem_we    = !in_fill;
    assign mem_addr  = in_fill ? {fill_tag, fill_idx, beat, 2'b00} : {wb_head.waddr, 2'b00};
    assign mem_be    = in_fill ? '1 : wb_head.be;
    assign mem_wdata = wb_head.data;

    assign ln_wr = (in_fill && mem_ack) || (wb_push && hit);

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= ST_IDLE;
            beat     <= '0;
            fill_idx <= '0;
            fill_tag <= '0;
        end else if (start_fill) begin
            state    <= ST_FILL;
            beat     <= '0;
            fill_idx <= a_idx;
            fill_tag <= a_tag;
        end else if (in_fill && mem_ack) begin
            beat <= beat + 1'b1;
            if (last_beat) state <= ST_IDLE;
        end
    end

    wtc_wbuf #(.DEPTH(WB_DEPTH)) u_wbuf (
        .clk(clk), .rst(rst), .push(wb_push), .push_data(wb_in), .pop(wb_pop),
        .head(wb_head), .empty(wb_empty), .full(wb_full)
    );

    wtc_lines #(.LINES(NUM_LINES), .WORDS(WORDS), .TAG_W(TAG_W)) u_lines (
        .clk(clk), .rst(rst),
        .rd_idx(a_idx), .rd_woff(a_woff), .rd_tag(a_tag), .hit(hit), .rd_word(line_word),
        .wr_en(ln_wr),
        .wr_idx(in_fill ? fill_idx : a_idx),
        .wr_woff(in_fill ? beat : a_woff),
        .wr_be(in_fill ? 4'hF : cpu_be),
        .wr_data(in_fill ? mem_rdata : cpu_wdata),
        .clr_en(start_fill), .clr_idx(a_idx),
        .set_en(last_beat), .set_idx(fill_idx), .set_tag(fill_tag)
    );

    // R10: a line fetch runs only with an empty store queue
    p_fill_drained_r10: assert property (@(posedge clk) disable iff (rst) in_fill |-> wb_empty);
    // R4: fetch beats are reads only
    p_fill_reads_r4: assert property (@(posedge clk) disable iff (rst) (in_fill && mem_req) |-> !mem_we);
    // R4: processor held while the line is incomplete
    p_fill_stalls_r4: assert property (@(posedge clk) disable iff (rst) in_fill |-> !cpu_ready);
    // R6: a memory request keeps its address until acknowledged
    p_req_hold_r6: assert property (@(posedge clk) disable iff (rst)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr)));
endmodule

// File: tb/wt_cache_tb.sv
`timescale 1ns/1ps
module wt_cache_tb_mem (
    input  logic        clk,
    input  logic        rst,
    input  logic        mem_req,
    input  logic        mem_we,
    input  logic [31:0] mem_addr,
    input  logic [3:0]  mem_be,
    input  logic [31:0] mem_wdata,
    output logic        mem_ack,
    output logic [31:0] mem_rdata,
    input  logic        st_acc,
    input  logic [31:0] st_addr,
    input  logic [3:0]  st_be,
    input  logic [31:0] st_data,
    input  int          lat
);
    logic [31:0] words [logic [29:0]];
    logic [65:0] pend [$];
    int rd_beats = 0, wr_beats = 0, chk = 0, err = 0, cnt = 0, k = 0;
    logic [31:0] base = '0;

    function automatic logic [31:0] init_word(input logic [29:0] wa);
        return ({wa, 2'b00} * 32'h0100_0193) ^ 32'h5A5A_5A5A;
    endfunction
    function automatic logic [31:0] peek(input logic [29:0] wa);
        return words.exists(wa) ? words[wa] : init_word(wa);
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            mem_ack <= 1'b0;
            cnt = 0;
        end else begin
            if (mem_req && mem_ack) begin
                chk++;
                if (mem_we) begin
                    wr_beats++;
                    if (pend.size() == 0 || pend[0] != {mem_addr[31:2], mem_be, mem_wdata}) begin
                        err++;
                        $display("FAIL R6 write act %h exp %h", {mem_addr[31:2], mem_be, mem_wdata},
                                 pend.size() ? pend[0] : 66'h0);
                    end
                    if (pend.size() != 0) void'(pend.pop_front());
                end else begin
                    rd_beats++;
                    if (pend.size() != 0) begin
                        err++;
                        $display("FAIL R10 fetch with pending stores act %0d exp 0", pend.size());
                    end
                    if (k == 0) base = {mem_addr[31:5], 5'b0};
                    if (mem_addr != base + 32'(4 * k) || mem_be != 4'hF) begin
                        err++;
                        $display("FAIL R4 beat addr act %h exp %h", mem_addr, base + 32'(4 * k));
                    end
                    k = (k + 1) % 8;
                end
            end
            if (st_acc) pend.push_back({st_addr[31:2], st_be, st_data});
            chk++;
            if (pend.size() > 4) begin
                err++;
                $display("FAIL R7 pending act %0d exp <=4", pend.size());
            end
            if (mem_req && !mem_ack) begin
                if (cnt >= lat) begin
                    mem_ack <= 1'b1;
                    cnt = 0;
                    if (mem_we) begin
                        logic [31:0] w;
                        w = peek(mem_addr[31:2]);
                        for (int i = 0; i < 4; i++) if (mem_be[i]) w[8*i +: 8] = mem_wdata[8*i +: 8];
                        words[mem_addr[31:2]] = w;
                    end else begin
                        mem_rdata <= peek(mem_addr[31:2]);
                    end
                end else begin
                    cnt++;
                end
            end else begin
                mem_ack <= 1'b0;
            end
        end
    end
endmodule

module wt_cache_tb;
    logic clk = 1'b0;
    logic rst = 1'b1;
    always #4 clk = ~clk;

    logic        req [2], we [2], rdy [2], m_req [2], m_we [2], m_ack [2];
    logic [31:0] ad [2], wd [2], rdat [2], m_addr [2], m_wdata [2], m_rdata [2];
    logic [3:0]  bes [2], m_be [2];
    int          lat [2];
    logic        acc [2];
    int checks = 0, errors = 0;
    bit done = 0;
    logic [31:0] shadow [logic [29:0]];
    logic [31:0] touched [$];
    int n_st0 = 0;

    assign acc[0] = req[0] && we[0] && rdy[0];
    assign acc[1] = req[1] && we[1] && rdy[1];

    wt_cache #(.WRITE_ALLOC(1'b0)) u_dut (
        .clk(clk), .rst(rst), .cpu_req(req[0]), .cpu_we(we[0]), .cpu_addr(ad[0]), .cpu_be(bes[0]),
        .cpu_wdata(wd[0]), .cpu_ready(rdy[0]), .cpu_rdata(rdat[0]), .mem_req(m_req[0]), .mem_we(m_we[0]),
        .mem_addr(m_addr[0]), .mem_be(m_be[0]), .mem_wdata(m_wdata[0]), .mem_ack(m_ack[0]), .mem_rdata(m_rdata[0]));
    wt_cache #(.WRITE_ALLOC(1'b1)) u_dut_wa (
        .clk(clk), .rst(rst), .cpu_req(req[1]), .cpu_we(we[1]), .cpu_addr(ad[1]), .cpu_be(bes[1]),
        .cpu_wdata(wd[1]), .cpu_ready(rdy[1]), .cpu_rdata(rdat[1]), .mem_req(m_req[1]), .mem_we(m_we[1]),
        .mem_addr(m_addr[1]), .mem_be(m_be[1]), .mem_wdata(m_wdata[1]), .mem_ack(m_ack[1]), .mem_rdata(m_rdata[1]));

    wt_cache_tb_mem u_m0 (.clk(clk), .rst(rst), .mem_req(m_req[0]), .mem_we(m_we[0]), .mem_addr(m_addr[0]),
        .mem_be(m_be[0]), .mem_wdata(m_wdata[0]), .mem_ack(m_ack[0]), .mem_rdata(m_rdata[0]),
        .st_acc(acc[0]), .st_addr(ad[0]), .st_be(bes[0]), .st_data(wd[0]), .lat(lat[0]));
    wt_cache_tb_mem u_m1 (.clk(clk), .rst(rst), .mem_req(m_req[1]), .mem_we(m_we[1]), .mem_addr(m_addr[1]),
        .mem_be(m_be[1]), .mem_wdata(m_wdata[1]), .mem_ack(m_ack[1]), .mem_rdata(m_rdata[1]),
        .st_acc(acc[1]), .st_addr(ad[1]), .st_be(bes[1]), .st_data(wd[1]), .lat(lat[1]));

    function automatic logic [31:0] view(input logic [31:0] a);
        return shadow.exists(a[31:2]) ? shadow[a[31:2]] : u_m0.init_word(a[31:2]);
    endfunction

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s act %h exp %h", tag, act, exp);
        end
    endtask

    task automatic access(input int w, input bit wr, input logic [31:0] a, input logic [3:0] be,
                          input logic [31:0] d, output logic [31:0] rd, output int waits);
        @(negedge clk);
        req[w] = 1'b1; we[w] = wr; ad[w] = a; bes[w] = be; wd[w] = d;
        waits = 0; rd = '0;
        forever begin
            #2;
            if (rdy[w]) begin rd = rdat[w]; break; end
            waits++;
            if (waits > 3000) break;
            @(negedge clk);
        end
        @(posedge clk);
        #1;
        req[w] = 1'b0;
        if (wr && w == 0) begin
            logic [31:0] v;
            v = view(a);
            for (int i = 0; i < 4; i++) if (be[i]) v[8*i +: 8] = d[8*i +: 8];
            shadow[a[31:2]] = v;
            touched.push_back(a);
            n_st0++;
        end
    endtask

    task automatic load0(input logic [31:0] a, input int exp_beats, input string tag);
        logic [31:0] rd; int wt, b0;
        b0 = u_m0.rd_beats;
        access(0, 1'b0, a, 4'h0, '0, rd, wt);
        check(rd == view(a), {tag, " data"}, rd, view(a));
        check(u_m0.rd_beats - b0 == exp_beats, {tag, " fetch beats"}, u_m0.rd_beats - b0, exp_beats);
        if (exp_beats == 0) check(wt == 0, {tag, " hit wait"}, wt, 0);
        else check(wt >= 8, {tag, " held until last beat"}, wt, 8);
    endtask

    initial begin
        #(8 * 150000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog act timeout exp completion");
            $display("Simulation finished: %0d checks, %0d errors", checks + u_m0.chk + u_m1.chk,
                     errors + u_m0.err + u_m1.err);
            $finish;
        end
    end

    initial begin
        logic [31:0] rd; int wt, wsum, b0, wcount;
        for (int i = 0; i < 2; i++) begin
            req[i] = 0; we[i] = 0; ad[i] = '0; bes[i] = '0; wd[i] = '0; lat[i] = 1;
        end
        repeat (4) @(posedge clk);
        @(negedge clk); rst = 1'b0;
        #2;
        check(m_req[0] == 1'b0, "R1 no request after reset", m_req[0], 0);
        // R1 / R4: cold miss
        load0(32'h0000_0100, 8, "R1 R4 cold load");
        // R3: hit on the same line, other word
        load0(32'h0000_011C, 0, "R3 hit");
        // R2: same index 8, tag 1 evicts, then the first line misses again
        load0(32'h0000_0500, 8, "R2 conflict");
        load0(32'h0000_0104, 8, "R2 evicted");
        load0(32'h0000_0120, 8, "R2 index 9");
        load0(32'h0000_0104, 0, "R2 index 8 kept");
        // R5: partial store on a hit
        access(0, 1'b1, 32'h0000_0104, 4'b0011, 32'hDEAD_BEEF, rd, wt);
        check(wt == 0, "R5 store hit accepted", wt, 0);
        load0(32'h0000_0104, 0, "R5 merged");
        // R7: burst of stores with slow memory
        lat[0] = 6; wsum = 0;
        for (int i = 0; i < 6; i++) begin
            access(0, 1'b1, 32'h0000_0108 + 32'(4 * (i % 4)), 4'hF, 32'hC0DE_0000 + 32'(i), rd, wt);
            wsum += wt;
        end
        check(wsum > 0, "R7 stall when full", wsum, 1);
        load0(32'h0000_010C, 0, "R7 R5 data after burst");
        // R8 / R10: store miss goes around, load right after waits for drain
        lat[0] = 2;
        b0 = u_m0.rd_beats;
        access(0, 1'b1, 32'h0000_2000, 4'b1100, 32'h1357_9BDF, rd, wt);
        check(u_m0.rd_beats == b0, "R8 no fetch on store miss", u_m0.rd_beats - b0, 0);
        load0(32'h0000_2000, 8, "R8 R10 line absent and fresh");
        // R6: drain and compare memory with processor view
        wcount = 0;
        while (u_m0.wr_beats != n_st0 && wcount < 500) begin @(posedge clk); wcount++; end
        check(u_m0.wr_beats == n_st0, "R6 write count", u_m0.wr_beats, n_st0);
        foreach (touched[i]) check(u_m0.peek(touched[i][31:2]) == view(touched[i]), "R6 memory image",
                                   u_m0.peek(touched[i][31:2]), view(touched[i]));
        // R9: write-allocate instance
        b0 = u_m1.rd_beats;
        access(1, 1'b1, 32'h0000_0040, 4'hF, 32'h1234_5678, rd, wt);
        check(u_m1.rd_beats - b0 == 8, "R9 fetch before store", u_m1.rd_beats - b0, 8);
        check(wt >= 8, "R9 store held for fetch", wt, 8);
        b0 = u_m1.rd_beats;
        access(1, 1'b0, 32'h0000_0044, 4'h0, '0, rd, wt);
        check(rd == u_m1.init_word(30'h11), "R9 neighbour word", rd, u_m1.init_word(30'h11));
        access(1, 1'b0, 32'h0000_0040, 4'h0, '0, rd, wt);
        check(rd == 32'h1234_5678, "R9 stored word in cache", rd, 32'h1234_5678);
        check(u_m1.rd_beats == b0, "R9 later loads hit", u_m1.rd_beats - b0, 0);
        repeat (20) @(posedge clk);
        check(u_m1.peek(30'h10) == 32'h1234_5678, "R9 R6 memory written", u_m1.peek(30'h10), 32'h1234_5678);
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks + u_m0.chk + u_m1.chk,
                 errors + u_m0.err + u_m1.err);
        $finish;
    end
endmodule